// File: doc/BRIEF.md
# PCM Bit-Clock and Frame-Sync Master with Idle Window

This block drives a PCM codec bus as its clock master. From the system clock it derives a bit clock whose half period is a programmable number of system cycles. It also makes a frame sync that marks the first bit period of every frame, where a frame is a programmable number of bit periods. Inside each frame a programmable idle window can be opened. While it is open the bit clock is held low, so the bus sees fewer clock pulses per frame than it has nominal bit periods. The frame timing is not changed by this.

The window is described by two counts, both measured in bit periods from the start of the frame: where the pause begins and where it ends. One position counter keeps running through the pause, so the frame sync period is always the full frame length. A third count gives the bit period at which the data slot ends. If that slot end reaches past the start of an enabled idle window, an error flag is raised for the frame, because the data would be cut off by the pause. All configuration is captured only when a frame begins. All outputs are registered.

Top module: `pcm_idle_clkgen`

## Requirements
- R1: While `rst_n` is low, and in the first system cycle after it is released, every output is 0. The first frame starts in the second cycle after release.
- R2: The bit clock period is 2*H system cycles, where H is `cfg_half_div`, or 1 when that input is 0. The clock is high for the first H cycles of each period and low for the last H cycles.
- R3: A frame is F bit periods, where F is `cfg_frame_len`, or 2 when that input is below 2. `fsync` is high for the whole of bit position 0 of each frame and low at every other position.
- R4: `frame_start` is high for exactly one system cycle, the first cycle of each frame.
- R5: Let S be `cfg_idle_start` and E be `cfg_idle_end`. When S < E <= F, the bit clock is held low and `idle` is high for the bit positions p with S <= p < E.
- R6: When S >= E or E > F, the window is disabled: `idle` stays 0 and the bit clock runs at every position.
- R7: The number of rising bit-clock edges per frame is F-(E-S) when the window is enabled, and F when it is disabled. The frame length stays F*2H system cycles either way.
- R8: Every high pulse of the bit clock lasts exactly H system cycles. `idle` rises only while the bit clock is already low.
- R9: `cfg_err` is high for the whole of a frame whose window is enabled and whose slot end `cfg_data_end` is greater than S. It is low in every other frame.
- R10: A configuration change in the middle of a frame has no effect until the next frame begins. The new values are then used for that whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_half_div | input | HALF_W | Bit clock half period in system cycles |
| cfg_frame_len | input | POS_W | Frame length in bit periods |
| cfg_idle_start | input | POS_W | Bit position at which the pause begins |
| cfg_idle_end | input | POS_W | Bit position at which the pause ends |
| cfg_data_end | input | POS_W | Bit position at which the data slot ends |
| bclk | output | 1 | Gated bit clock |
| fsync | output | 1 | Frame sync, high during bit position 0 |
| frame_start | output | 1 | One-cycle strobe at the first cycle of a frame |
| idle | output | 1 | High while the idle window is open |
| cfg_err | output | 1 | Slot end passes an enabled idle start |

## Verification
The assertions assume that every bit period is at least two system cycles and every frame at least two bit periods. The clamping of a zero divider and a short frame length guarantees this, so the stimulus may drive those inputs with zero. They also assume that configuration inputs reach the block only through the frame-start capture. To keep this, the stimulus changes the inputs either under reset or once in the middle of a frame, and holds them steady across every frame boundary. Random configurations are kept small, so that enabled windows, disabled windows (S >= E and E > F), and slot ends on both sides of S all occur several times.

// File: rtl/pcm_idle_pkg.sv
package pcm_idle_pkg;

  // Registered output bundle of the generator
  typedef struct packed {
    logic bclk;
    logic fsync;
    logic fstart;
    logic idle;
    logic err;
  } pcm_out_t;

  localparam pcm_out_t PCM_OUT_RST = '{bclk: 1'b0, fsync: 1'b0, fstart: 1'b0,
                                       idle: 1'b0, err: 1'b0};

endpackage

// File: rtl/pcm_cfg_shadow.sv
// Holds the configuration for the running frame; captures only on load.
module pcm_cfg_shadow #(
  parameter int HALF_W = 8,
  parameter int POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] in_half,
  input  logic [POS_W-1:0]  in_flen,
  input  logic [POS_W-1:0]  in_istart,
  input  logic [POS_W-1:0]  in_iend,
  input  logic [POS_W-1:0]  in_dend,
  output logic [HALF_W-1:0] half_q,
  output logic [POS_W-1:0]  flen_q,
  output logic [POS_W-1:0]  istart_q,
  output logic [POS_W-1:0]  iend_q,
  output logic              win_en_q,
  output logic              err_q
);

  localparam logic [POS_W-1:0]  MIN_FLEN = POS_W'(2);
  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(1);

  logic [HALF_W-1:0] half_d;
  logic [POS_W-1:0]  flen_d, istart_d, iend_d;
  logic              win_en_d, err_d;
  logic [HALF_W-1:0] half_clamp;
  logic [POS_W-1:0]  flen_clamp;
  logic              win_ok;

  always_comb begin
    half_clamp = (in_half == '0) ? MIN_HALF : in_half;
    flen_clamp = (in_flen < MIN_FLEN) ? MIN_FLEN : in_flen;
    win_ok     = (in_istart < in_iend) && (in_iend <= flen_clamp);

    half_d   = half_q;
    flen_d   = flen_q;
    istart_d = istart_q;
    iend_d   = iend_q;
    win_en_d = win_en_q;
    err_d    = err_q;
    if (load) begin
      half_d   = half_clamp;
      flen_d   = flen_clamp;
      istart_d = in_istart;
      iend_d   = in_iend;
      win_en_d = win_ok;
      err_d    = win_ok && (in_dend > in_istart);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= MIN_HALF;
      flen_q   <= MIN_FLEN;
      istart_q <= '0;
      iend_q   <= '0;
      win_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      half_q   <= half_d;
      flen_q   <= flen_d;
      istart_q <= istart_d;
      iend_q   <= iend_d;
      win_en_q <= win_en_d;
      err_q    <= err_d;
    end
  end

  // R2/R3: the held configuration never carries an unclamped value
  a_r3_shadow_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q != '0) && (flen_q >= MIN_FLEN));

endmodule

// File: rtl/pcm_frame_timer.sv
// Phase counter inside a bit period and position counter inside a frame.
module pcm_frame_timer #(
  parameter int HALF_W = 8,
  parameter int POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half,
  input  logic [POS_W-1:0]  flen,
  output logic              primed,
  output logic [HALF_W:0]   phase,
  output logic [POS_W-1:0]  pos,
  output logic              load
);

  localparam int PH_W = HALF_W + 1;

  logic [PH_W-1:0]  ph_last;
  logic [POS_W-1:0] pos_last;
  logic             ph_wrap, pos_wrap;
  logic             primed_d;
  logic [PH_W-1:0]  phase_d;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    ph_last  = {half, 1'b0} - PH_W'(1);
    pos_last = flen - POS_W'(1);
    ph_wrap  = (phase >= ph_last);
    pos_wrap = (pos >= pos_last);
    load     = !primed || (ph_wrap && pos_wrap);

    primed_d = 1'b1;
    phase_d  = phase;
    pos_d    = pos;
    if (primed) begin
      if (ph_wrap) begin
        phase_d = '0;
        pos_d   = pos_wrap ? '0 : pos + POS_W'(1);
      end else begin
        phase_d = phase + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      phase  <= '0;
      pos    <= '0;
    end else begin
      primed <= primed_d;
      phase  <= phase_d;
      pos    <= pos_d;
    end
  end

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < {half, 1'b0});

  a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos < flen);

endmodule

// File: rtl/pcm_edge_gen.sv
// Decodes counter state into the registered bus outputs.
module pcm_edge_gen #(
  parameter int HALF_W = 8,
  parameter int POS_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   primed,
  input  logic [HALF_W:0]        phase,
  input  logic [POS_W-1:0]       pos,
  input  logic [HALF_W-1:0]      half,
  input  logic [POS_W-1:0]       istart,
  input  logic [POS_W-1:0]       iend,
  input  logic                   win_en,
  input  logic                   err_flag,
  output pcm_idle_pkg::pcm_out_t out_q
);

  import pcm_idle_pkg::*;

  pcm_out_t out_d;
  logic     nominal_hi, in_window, at_pos0;

  // The window can only change when the position changes, which is
  // also the start of a period: the previous cycle was low, so gating
  // never cuts a pulse short.
  always_comb begin
    nominal_hi   = (phase < {1'b0, half});
    in_window    = win_en && (pos >= istart) && (pos < iend);
    at_pos0      = (pos == '0);
    out_d.bclk   = primed && nominal_hi && !in_window;
    out_d.fsync  = primed && at_pos0;
    out_d.fstart = primed && at_pos0 && (phase == '0);
    out_d.idle   = primed && in_window;
    out_d.err    = primed && err_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= PCM_OUT_RST;
    else        out_q <= out_d;
  end

  a_r8_idle_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.idle) |-> !$past(out_q.bclk));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.fstart |=> !out_q.fstart);

  a_r3_sync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.fsync) |-> out_q.fstart);

endmodule

// File: rtl/pcm_idle_clkgen.sv
module pcm_idle_clkgen #(
  parameter int HALF_W = 8,
  parameter int POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half_div,
  input  logic [POS_W-1:0]  cfg_frame_len,
  input  logic [POS_W-1:0]  cfg_idle_start,
  input  logic [POS_W-1:0]  cfg_idle_end,
  input  logic [POS_W-1:0]  cfg_data_end,
  output logic              bclk,
  output logic              fsync,
  output logic              frame_start,
  output logic              idle,
  output logic              cfg_err
);

  import pcm_idle_pkg::*;

  logic [HALF_W-1:0] half_s;
  logic [POS_W-1:0]  flen_s, istart_s, iend_s;
  logic              win_en_s, err_s;
  logic              primed, load;
  logic [HALF_W:0]   phase;
  logic [POS_W-1:0]  pos;
  pcm_out_t          outs;

  pcm_cfg_shadow #(.HALF_W(HALF_W), .POS_W(POS_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_half(cfg_half_div), .in_flen(cfg_frame_len),
    .in_istart(cfg_idle_start), .in_iend(cfg_idle_end), .in_dend(cfg_data_end),
    .half_q(half_s), .flen_q(flen_s), .istart_q(istart_s), .iend_q(iend_s),
    .win_en_q(win_en_s), .err_q(err_s)
  );

  pcm_frame_timer #(.HALF_W(HALF_W), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .half(half_s), .flen(flen_s),
    .primed(primed), .phase(phase), .pos(pos), .load(load)
  );

  pcm_edge_gen #(.HALF_W(HALF_W), .POS_W(POS_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .primed(primed), .phase(phase), .pos(pos),
    .half(half_s), .istart(istart_s), .iend(iend_s), .win_en(win_en_s),
    .err_flag(err_s), .out_q(outs)
  );

  assign bclk        = outs.bclk;
  assign fsync       = outs.fsync;
  assign frame_start = outs.fstart;
  assign idle        = outs.idle;
  assign cfg_err     = outs.err;

  // R10/R9: the error flag moves only together with a frame start
  a_r10_err_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> frame_start);

endmodule

// File: tb/sim_pcm_idle_clkgen.sv
module sim_pcm_idle_clkgen;

  localparam int HW = 8;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [HW-1:0] c_half;
  logic [PW-1:0] c_flen, c_is, c_ie, c_de;
  logic          bclk, fsync, frame_start, idle, cfg_err;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  pcm_idle_clkgen #(.HALF_W(HW), .POS_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_half_div(c_half), .cfg_frame_len(c_flen),
    .cfg_idle_start(c_is), .cfg_idle_end(c_ie), .cfg_data_end(c_de),
    .bclk(bclk), .fsync(fsync), .frame_start(frame_start),
    .idle(idle), .cfg_err(cfg_err)
  );

  function automatic int hpe(int h); return (h == 0) ? 1 : h; endfunction
  function automatic int fle(int f); return (f < 2) ? 2 : f; endfunction
  function automatic bit win_on(int s, int e, int f);
    return (s < e) && (e <= fle(f));
  endfunction

  task automatic chk(string req, logic got, logic exp, int t);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, got, exp);
    end
  endtask

  task automatic chk_int(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic drive(int h, int f, int s, int e, int d);
    c_half = HW'(h); c_flen = PW'(f); c_is = PW'(s); c_ie = PW'(e); c_de = PW'(d);
  endtask

  // R1: reset and the priming cycle keep all outputs low
  task automatic reset_with(int h, int f, int s, int e, int d);
    @(negedge clk);
    drive(h, f, s, e, d);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 bclk in reset", bclk, 1'b0, -1);
    chk("R1 fsync in reset", fsync | frame_start | idle | cfg_err, 1'b0, -1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after release", bclk | fsync | frame_start | idle | cfg_err, 1'b0, -1);
  endtask

  // Runs nfr frames against the model; with chg, new values arrive mid frame 0
  task automatic run(int nfr, bit chg, int nh, int nf, int ns, int ne, int nd);
    int    h = int'(c_half);
    int    f = int'(c_flen);
    int    s = int'(c_is);
    int    e = int'(c_ie);
    int    d = int'(c_de);
    int    t = 0;
    int    fr = 0;
    int    rises = 0;
    int    hi_len = 0;
    logic  prev = 1'b0;
    string pfx;
    while (fr < nfr) begin
      int per = 2 * hpe(h);
      int fs  = per * fle(f);
      int pos = t / per;
      int ph  = t % per;
      bit en  = win_on(s, e, f);
      bit idl = en && (pos >= s) && (pos < e);
      pfx = chg ? "R10/" : "";
      @(negedge clk);
      chk({pfx, idl ? "R5 bclk held" : (en ? "R2 bclk" : "R6 bclk free")},
          bclk, (ph < hpe(h)) && !idl, t);
      chk({pfx, "R3 fsync"}, fsync, pos == 0, t);
      chk({pfx, "R4 frame_start"}, frame_start, t == 0, t);
      chk({pfx, en ? "R5 idle" : "R6 idle off"}, idle, idl, t);
      chk({pfx, "R9 cfg_err"}, cfg_err, en && (d > s), t);
      if (bclk && !prev) rises++;
      if (bclk) hi_len++;
      else begin
        if (prev) chk_int({pfx, "R8 high pulse width"}, hi_len, hpe(h));
        hi_len = 0;
      end
      prev = bclk;
      if (chg && fr == 0 && t == fs / 2) drive(nh, nf, ns, ne, nd);
      t++;
      if (t == fs) begin
        chk_int({pfx, "R7 pulses per frame"}, rises,
                en ? fle(f) - (e - s) : fle(f));
        rises = 0;
        t = 0;
        fr++;
        h = int'(c_half); f = int'(c_flen); s = int'(c_is);
        e = int'(c_ie);   d = int'(c_de);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(1, 4, 0, 0, 0);

    // R5/R7: 100-period frame with pause 60..90 gives 70 pulses
    reset_with(1, 100, 60, 90, 50);
    run(2, 1'b0, 0, 0, 0, 0, 0);
    // R6: empty window and window past frame end
    reset_with(1, 20, 10, 10, 4);
    run(2, 1'b0, 0, 0, 0, 0, 0);
    reset_with(2, 12, 4, 13, 2);
    run(2, 1'b0, 0, 0, 0, 0, 0);
    // R2/R3: zero divider and zero length clamp
    reset_with(0, 0, 0, 1, 0);
    run(3, 1'b0, 0, 0, 0, 0, 0);
    // R9: slot end beyond idle start
    reset_with(1, 20, 5, 15, 8);
    run(2, 1'b0, 0, 0, 0, 0, 0);
    // R9: slot end equal to idle start is fine
    reset_with(3, 10, 6, 9, 6);
    run(2, 1'b0, 0, 0, 0, 0, 0);
    // R10: mid-frame change
    reset_with(1, 16, 8, 12, 4);
    run(3, 1'b1, 2, 10, 3, 7, 5);

    for (int i = 0; i < 40; i++) begin
      int h = int'($urandom % 4);
      int f = int'($urandom % 25);
      int s = int'($urandom % 27);
      int e = int'($urandom % 27);
      int d = int'($urandom % 27);
      reset_with(h, f, s, e, d);
      if (i % 5 == 0)
        run(3, 1'b1, int'($urandom % 4), int'($urandom % 25),
            int'($urandom % 27), int'($urandom % 27), int'($urandom % 27));
      else
        run(2, 1'b0, 0, 0, 0, 0, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule